// File: doc/BRIEF.md
# Floating-Point Register High-Half Move Unit

This unit carries out the two moves between the upper half of a floating-point register and a general-purpose register. The "move from high" operation returns the upper 32 bits of a floating-point register, sign-extended to 64 bits, as write data for a general register. The "move to high" operation places the low 32 bits of a general-register operand into the upper half of a floating-point register. The unit owns a file of 32 floating-point registers, each 64 bits wide, and exposes that file's write port so that the surrounding pipeline can see every update.

The register file works in one of two layouts, selected by a mode input. In the wide layout each register holds a full 64-bit value. In the paired layout only the low 32 bits of each register are used, and the upper half of an even register lives in the next odd register. In the paired layout an odd register number has no valid partner. The unit does not trap on this case. A read returns a fixed marker word, and a write stores a different fixed marker word into the named register.

Decode, result selection and the write port are combinational within the instruction's cycle. The register file updates on the following clock edge. When the coprocessor-enable input is low, a recognised instruction only raises an unusable flag.

Top module: `fhm_unit`

## Requirements
- R1: After reset every floating-point register reads as zero. When no instruction is accepted, every output is zero: both write enables, both write addresses, both write data words and the unusable flag.
- R2: An instruction is recognised only when `insn_valid` is high, bits 31:26 are 010001, bits 10:0 are all zero, and bits 25:21 are 00011 (move from high) or 00111 (move to high). Bits 20:16 name the general register and bits 15:11 name the floating-point register `fs`. Any other word, or `insn_valid` low, gives the idle outputs of R1 and leaves the register file unchanged.
- R3: In wide mode (`wide_mode`=1), move-from-high drives `gpr_we`=1, `gpr_waddr`=bits 20:16 and `gpr_wdata` = bits 63:32 of register `fs`, sign-extended from bit 31.
- R4: In wide mode, move-to-high writes register `fs` with `rt_val[31:0]` in bits 63:32 and the old bits 31:0 unchanged. `rt_val[63:32]` has no effect.
- R5: In paired mode (`wide_mode`=0) with `fs` even, move-from-high returns bits 31:0 of register `fs+1`, sign-extended.
- R6: In paired mode with `fs` even, move-to-high writes register `fs+1`: bits 31:0 take `rt_val[31:0]` and bits 63:32 keep their old value.
- R7: In paired mode with `fs` odd, move-from-high returns 0x000000000BADF00D.
- R8: In paired mode with `fs` odd, move-to-high writes register `fs`: bits 31:0 take 0xDEADC0DE and bits 63:32 keep their old value.
- R9: With `fpu_on` low, a recognised instruction drives `cop_unusable`=1 and both write enables low. The register file is unchanged.
- R10: The write port value is formed from the register contents before the edge. A write takes effect at the clock edge and is seen by an instruction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the register file |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| rt_val | input | 64 | General-register operand for move-to-high |
| wide_mode | input | 1 | 1 = 64-bit register layout, 0 = paired 32-bit layout |
| fpu_on | input | 1 | Coprocessor enabled |
| gpr_we | output | 1 | General-register write enable |
| gpr_waddr | output | 5 | General-register destination |
| gpr_wdata | output | 64 | General-register write data |
| fpr_we | output | 1 | Floating-point register write enable |
| fpr_waddr | output | 5 | Floating-point register written |
| fpr_wdata | output | 64 | Full 64-bit value written |
| cop_unusable | output | 1 | Recognised instruction while the coprocessor is disabled |

## Verification
The bench sweeps every register number in both layouts, with write operands whose upper halves are garbage and whose bit 31 varies. This catches a design that forgets sign extension or lets `rt_val[63:32]` leak into a register. Odd numbers in paired mode are written first and even numbers after them, so the two marker words, and a design that aims an even access at `fs` instead of `fs+1`, show up as wrong data on readback. Wide-mode writes on top of paired-mode contents expose a merge that clobbers the low half. A write followed at once by a read of the same register catches an off-by-one-cycle update. Malformed encodings and the disabled case are followed by full readback, which reveals any stray write.

// File: rtl/fhm_pkg.sv
package fhm_pkg;
  localparam int unsigned FPR_W  = 64;
  localparam int unsigned HALF_W = 32;

  localparam logic [5:0]  OP_COP1    = 6'b010001;
  localparam logic [4:0]  SUB_MFH    = 5'b00011;
  localparam logic [4:0]  SUB_MTH    = 5'b00111;
  localparam logic [31:0] MARK_READ  = 32'h0BADF00D;
  localparam logic [31:0] MARK_WRITE = 32'hDEADC0DE;

  typedef enum logic [1:0] {K_NONE, K_MFH, K_MTH} kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [4:0] gpr;
    logic [4:0] fs;
  } dec_t;

  function automatic logic [FPR_W-1:0] sext_half(input logic [HALF_W-1:0] v);
    return {{(FPR_W-HALF_W){v[HALF_W-1]}}, v};
  endfunction

  // Register that actually holds the upper half for this access.
  function automatic logic [4:0] home_index(input logic [4:0] fs, input logic wide);
    return (!wide && !fs[0]) ? (fs | 5'd1) : fs;
  endfunction

  function automatic logic [FPR_W-1:0] read_high(input logic [FPR_W-1:0] cur,
                                                 input logic wide,
                                                 input logic odd);
    if (wide)     return sext_half(cur[FPR_W-1:HALF_W]);
    else if (odd) return sext_half(MARK_READ);
    else          return sext_half(cur[HALF_W-1:0]);
  endfunction

  function automatic logic [FPR_W-1:0] merge_high(input logic [FPR_W-1:0] cur,
                                                  input logic [HALF_W-1:0] src,
                                                  input logic wide,
                                                  input logic odd);
    if (wide)     return {src, cur[HALF_W-1:0]};
    else if (odd) return {cur[FPR_W-1:HALF_W], MARK_WRITE};
    else          return {cur[FPR_W-1:HALF_W], src};
  endfunction
endpackage

// File: rtl/fhm_decode.sv
module fhm_decode
  import fhm_pkg::*;
(
  input  logic        insn_valid,
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic op_hit;
  logic tail_zero;

  assign op_hit    = insn_valid && (insn[31:26] == OP_COP1);
  assign tail_zero = (insn[10:0] == 11'd0);

  always_comb begin
    dec.gpr  = insn[20:16];
    dec.fs   = insn[15:11];
    dec.kind = K_NONE;
    if (op_hit && tail_zero) begin
      unique case (insn[25:21])
        SUB_MFH: dec.kind = K_MFH;
        SUB_MTH: dec.kind = K_MTH;
        default: dec.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fhm_fpr_file.sv
module fhm_fpr_file #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 64,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0]    mem [NREG];
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = we && (waddr == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (hit[i]) mem[i] <= wdata;
    end
  end

  assign rd_data = mem[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata)); // R10
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R10
endmodule

// File: rtl/fhm_exec.sv
module fhm_exec
  import fhm_pkg::*;
(
  input  dec_t               dec,
  input  logic [FPR_W-1:0]   rt_val,
  input  logic               wide_mode,
  input  logic               fpu_on,
  input  logic [FPR_W-1:0]   cur_val,
  output logic [4:0]         rd_addr,
  output logic               gpr_we,
  output logic [4:0]         gpr_waddr,
  output logic [FPR_W-1:0]   gpr_wdata,
  output logic               fpr_we,
  output logic [4:0]         fpr_waddr,
  output logic [FPR_W-1:0]   fpr_wdata,
  output logic               cop_unusable
);
  logic recognised;
  logic granted;
  logic fs_odd;
  logic unused_rt_hi;

  assign recognised   = (dec.kind != K_NONE);
  assign granted      = recognised && fpu_on;
  assign fs_odd       = dec.fs[0];
  assign rd_addr      = home_index(dec.fs, wide_mode);
  assign unused_rt_hi = ^rt_val[FPR_W-1:HALF_W];

  always_comb begin
    gpr_we       = 1'b0;
    gpr_waddr    = '0;
    gpr_wdata    = '0;
    fpr_we       = 1'b0;
    fpr_waddr    = '0;
    fpr_wdata    = '0;
    cop_unusable = recognised && !fpu_on;
    if (granted && dec.kind == K_MFH) begin
      gpr_we    = 1'b1;
      gpr_waddr = dec.gpr;
      gpr_wdata = read_high(cur_val, wide_mode, fs_odd);
    end
    if (granted && dec.kind == K_MTH) begin
      fpr_we    = 1'b1;
      fpr_waddr = rd_addr;
      fpr_wdata = merge_high(cur_val, rt_val[HALF_W-1:0], wide_mode, fs_odd);
    end
  end
endmodule

// File: rtl/fhm_unit.sv
module fhm_unit
  import fhm_pkg::*;
#(
  parameter int unsigned NREG = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  input  logic [63:0] rt_val,
  input  logic        wide_mode,
  input  logic        fpu_on,
  output logic        gpr_we,
  output logic [4:0]  gpr_waddr,
  output logic [63:0] gpr_wdata,
  output logic        fpr_we,
  output logic [4:0]  fpr_waddr,
  output logic [63:0] fpr_wdata,
  output logic        cop_unusable
);
  dec_t             dec;
  logic [4:0]       rd_addr;
  logic [FPR_W-1:0] cur_val;

  fhm_decode u_dec (
    .insn_valid (insn_valid),
    .insn       (insn),
    .dec        (dec)
  );

  fhm_fpr_file #(.NREG(NREG), .W(FPR_W)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (cur_val),
    .we      (fpr_we),
    .waddr   (fpr_waddr),
    .wdata   (fpr_wdata)
  );

  fhm_exec u_exec (
    .dec          (dec),
    .rt_val       (rt_val),
    .wide_mode    (wide_mode),
    .fpu_on       (fpu_on),
    .cur_val      (cur_val),
    .rd_addr      (rd_addr),
    .gpr_we       (gpr_we),
    .gpr_waddr    (gpr_waddr),
    .gpr_wdata    (gpr_wdata),
    .fpr_we       (fpr_we),
    .fpr_waddr    (fpr_waddr),
    .fpr_wdata    (fpr_wdata),
    .cop_unusable (cop_unusable)
  );

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(gpr_we && fpr_we)); // R2
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !fpu_on |-> !gpr_we && !fpr_we); // R9
  AST_FLAG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cop_unusable |-> !gpr_we && !fpr_we); // R9
  AST_WIDE_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fpr_we && wide_mode |-> fpr_wdata[31:0] == cur_val[31:0]); // R4
  AST_PAIRED_ODD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    fpr_we && !wide_mode |-> fpr_waddr[0] && fpr_wdata[63:32] == cur_val[63:32]); // R6
  AST_READ_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we && !wide_mode && insn[11] |-> gpr_wdata == 64'h0000_0000_0BAD_F00D); // R7
  AST_WRITE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    fpr_we && !wide_mode && insn[11] |-> fpr_wdata[31:0] == 32'hDEAD_C0DE); // R8
endmodule

// File: tb/fhm_unit_tb.sv
`timescale 1ns/1ps
module fhm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] rt_val = '0;
  logic        wide_mode = 1'b1;
  logic        fpu_on = 1'b1;
  logic        gpr_we, fpr_we, cop_unusable;
  logic [4:0]  gpr_waddr, fpr_waddr;
  logic [63:0] gpr_wdata, fpr_wdata;

  int unsigned total = 0;
  int unsigned fails = 0;
  logic [63:0] model [32];

  always #2 clk = ~clk;

  fhm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .rt_val(rt_val), .wide_mode(wide_mode), .fpu_on(fpu_on),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .fpr_we(fpr_we), .fpr_waddr(fpr_waddr), .fpr_wdata(fpr_wdata),
    .cop_unusable(cop_unusable)
  );

  function automatic logic [31:0] enc(input logic [4:0] sub, input logic [4:0] g, input logic [4:0] f);
    return {6'b010001, sub, g, f, 11'd0};
  endfunction

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] pat(input int unsigned f, input logic [31:0] seed);
    logic [31:0] lo;
    lo = 32'(seed * (f + 1));
    return {32'hF0F0_0000 | 32'(f), lo};
  endfunction

  // One instruction: drive, compare every output with the model, step the model.
  task automatic run(input logic v, input logic [31:0] w, input logic [63:0] rv,
                     input logic wide, input logic on, input string req);
    logic [142:0] act, exp;
    logic legal, e_gwe, e_fwe, e_cu;
    logic [4:0] e_ga, e_fa, f;
    logic [63:0] e_gd, e_fd;
    @(negedge clk);
    insn_valid = v; insn = w; rt_val = rv; wide_mode = wide; fpu_on = on;
    #1;
    f = w[15:11];
    legal = v && (w[31:26] == 6'd17) && (w[10:0] == 11'd0) &&
            (w[25:21] == 5'd3 || w[25:21] == 5'd7);
    e_gwe = 0; e_fwe = 0; e_ga = 0; e_fa = 0; e_gd = 0; e_fd = 0;
    e_cu = legal && !on;
    if (legal && on && w[25:21] == 5'd3) begin
      e_gwe = 1; e_ga = w[20:16];
      if (wide)          e_gd = sx(model[f][63:32]);
      else if (f % 2)    e_gd = 64'h0BADF00D;
      else               e_gd = sx(model[f + 5'd1][31:0]);
    end
    if (legal && on && w[25:21] == 5'd7) begin
      e_fwe = 1;
      if (wide)        begin e_fa = f;        e_fd = {rv[31:0], model[f][31:0]}; end
      else if (f % 2)  begin e_fa = f;        e_fd = {model[f][63:32], 32'hDEADC0DE}; end
      else             begin e_fa = f + 5'd1; e_fd = {model[e_fa][63:32], rv[31:0]}; end
    end
    exp = {e_gwe, e_ga, e_gd, e_fwe, e_fa, e_fd, e_cu};
    act = {gpr_we, gpr_waddr, gpr_wdata, fpr_we, fpr_waddr, fpr_wdata, cop_unusable};
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s insn=%h actual=%h expected=%h", req, w, act, exp);
    end
    if (e_fwe) model[e_fa] = e_fd;
  endtask

  initial begin
    #600000;
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs and cleared file
    run(0, enc(5'd3, 5'd1, 5'd0), 64'h1, 1, 1, "R1");
    for (int f = 0; f < 32; f++) run(1, enc(5'd3, 5'(f), 5'(f)), 0, 1, 1, "R1");
    // R8 then R6: paired writes, odd numbers first
    for (int f = 1; f < 32; f += 2) run(1, enc(5'd7, 5'd0, 5'(f)), pat(f, 32'h9E37_79B9), 0, 1, "R8");
    for (int f = 0; f < 32; f += 2) run(1, enc(5'd7, 5'd0, 5'(f)), pat(f, 32'h1357_9BDF), 0, 1, "R6");
    // R5 / R7: paired reads
    for (int f = 0; f < 32; f++) run(1, enc(5'd3, 5'(31 - f), 5'(f)), 0, 0, 1, (f % 2) ? "R7" : "R5");
    // R4: wide writes over paired contents, low halves kept
    for (int f = 0; f < 32; f++) run(1, enc(5'd7, 5'd2, 5'(f)), pat(f, 32'h8421_0F0F), 1, 1, "R4");
    // R3: wide reads, sign extension
    for (int f = 0; f < 32; f++) run(1, enc(5'd3, 5'(f), 5'(f)), 0, 1, 1, "R3");
    // R5 again: paired read sees low half of fs+1 after wide writes
    for (int f = 0; f < 32; f += 2) run(1, enc(5'd3, 5'd7, 5'(f)), 0, 0, 1, "R5");
    // R9: disabled coprocessor
    run(1, enc(5'd7, 5'd0, 5'd4), 64'h5555_5555_7777_7777, 1, 0, "R9");
    run(1, enc(5'd3, 5'd9, 5'd4), 0, 0, 0, "R9");
    run(1, enc(5'd7, 5'd0, 5'd5), 64'h1, 0, 0, "R9");
    // R2: malformed words and invalid strobe
    run(1, enc(5'd7, 5'd0, 5'd4) | 32'h1, 64'hAAAA_AAAA, 1, 1, "R2");
    run(1, enc(5'd7, 5'd0, 5'd6) | 32'h400, 64'hAAAA_AAAA, 1, 1, "R2");
    run(1, enc(5'd7, 5'd0, 5'd4) ^ 32'h8000_0000, 64'hAAAA_AAAA, 1, 1, "R2");
    run(1, enc(5'd6, 5'd0, 5'd4), 64'hAAAA_AAAA, 1, 1, "R2");
    run(1, enc(5'd2, 5'd0, 5'd4), 64'hAAAA_AAAA, 1, 1, "R2");
    run(0, enc(5'd7, 5'd0, 5'd4), 64'hAAAA_AAAA, 1, 1, "R2");
    for (int f = 0; f < 32; f++) run(1, enc(5'd3, 5'd1, 5'(f)), 0, 1, 1, "R2");
    // R10: back-to-back write then read of the same register
    run(1, enc(5'd7, 5'd0, 5'd5), 64'h0000_0000_7654_3210, 1, 1, "R10");
    run(1, enc(5'd3, 5'd3, 5'd5), 0, 1, 1, "R10");
    run(1, enc(5'd7, 5'd0, 5'd10), 64'h0000_0000_CAFE_0001, 0, 1, "R10");
    run(1, enc(5'd3, 5'd3, 5'd10), 0, 0, 1, "R10");
    run(1, enc(5'd3, 5'd3, 5'd11), 0, 1, 1, "R10");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule